// File: doc/BRIEF.md
# State-Slaved General-Purpose Output Driver

This block drives four general-purpose output pins from the state of a transceiver's operating state machine. Each pin can be set to follow entry into the receive state, the transmit state, or both. On entry the pin keeps its resting level for a programmable number of microsecond ticks and then flips. Leaving the active state puts it back at its resting level at once. Each pin has its own resting polarity, which applies in the alert, receive and transmit states. In sleep and wait every automatic pin is low.

Two overrides sit above the automatic behaviour. A manual mode drives all four pins straight from a 4-bit mask. A routing option lets the external-LNA control bit of receive channel 1 drive pin 0, and that of channel 2 drive pin 1. Manual mode takes priority over routing, and routing takes priority over state slaving.

Each pin has its own tracking machine with five states:
- IDLE: nothing is pending.
- RX_WAIT and TX_WAIT: the delay is counting down.
- RX_ON and TX_ON: the pin is flipped.

The transitions are:
- load: from any state whose mode has ended into a WAIT state, or straight to an ON state when the delay is zero.
- expire: WAIT to ON on the final tick.
- drop: back to IDLE when the state code leaves the followed state or the follow enable is cleared.
- switch: receive to transmit or the reverse. This is a drop and a load in the same edge.

Top module: `gpo_state_slave`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with the state code at sleep, all four pins are low. The state codes are sleep=0, wait=1, alert=2, receive=3 and transmit=4.
- R2: In sleep (0) and wait (1) every automatically driven pin is low. In alert (2) pin i equals `cfg_idle_high[i]`.
- R3: With `cfg_follow_rx[i]` set, entering receive (3) keeps pin i at `cfg_idle_high[i]` until the d-th `us_tick` seen at a clock edge after the entry edge. Here d is `cfg_rx_dly[8*i+7:8*i]`. The pin then shows `~cfg_idle_high[i]`. When d=0 it flips right after the entry edge.
- R4: The same rule holds for transmit (4), using `cfg_follow_tx[i]` and `cfg_tx_dly[8*i+7:8*i]`.
- R5: A pin whose follow enable for the current active state is clear stays at `cfg_idle_high[i]` in that state.
- R6: Leaving the followed state returns the pin to its resting level in the same cycle, before any clock edge. A pending delay is cancelled, so a later entry counts the full delay again.
- R7: Clock edges without `us_tick` do not advance the delay.
- R8: A direct receive-to-transmit change starts the transmit delay at the first edge in transmit.
- R9: With `man_en` high, pin i equals `man_mask[i]`. This overrides routing and slaving.
- R10: With `man_en` low and `lna_route_en[0]` set, pin 0 equals `lna_bit[0]`. With `lna_route_en[1]` set, pin 1 equals `lna_bit[1]`. Pins 2 and 3 are never routed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trx_state | input | 3 | Operating state code (0 sleep, 1 wait, 2 alert, 3 receive, 4 transmit) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cfg_idle_high | input | 4 | Per-pin resting polarity |
| cfg_follow_rx | input | 4 | Per-pin follow enable for receive |
| cfg_follow_tx | input | 4 | Per-pin follow enable for transmit |
| cfg_rx_dly | input | 32 | Per-pin receive delay in ticks, 8 bits each |
| cfg_tx_dly | input | 32 | Per-pin transmit delay in ticks, 8 bits each |
| man_en | input | 1 | Manual override enable |
| man_mask | input | 4 | Manual pin levels |
| lna_route_en | input | 2 | Route channel LNA bit to pin 0 / pin 1 |
| lna_bit | input | 2 | External-LNA control bits of channels 1 and 2 |
| gpo_out | output | 4 | Output pins |

## Verification
Each pin carries a delay counter that is hidden behind its output. A wrong count or a missed cancel therefore only shows as a flip that comes one tick early or late, or one that never comes. For this reason the delays are swept per pin and per direction, and each sweep samples the pin just before and just after the tick on which it should flip. A stale tracking state left over after an exit shows on the first re-entry as an early flip. The cancel test is built to reveal exactly that within a few ticks. Priority faults show in the same cycle as the override input changes.

// File: rtl/gpo_pkg.sv
`timescale 1ns/1ps
package gpo_pkg;
    typedef enum logic [2:0] {
        TRX_SLEEP = 3'd0,
        TRX_WAIT  = 3'd1,
        TRX_ALERT = 3'd2,
        TRX_RX    = 3'd3,
        TRX_TX    = 3'd4
    } trx_state_e;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_RX_WAIT,
        SL_RX_ON,
        SL_TX_WAIT,
        SL_TX_ON
    } slave_state_e;
endpackage

// File: rtl/gpo_slave_fsm.sv
`timescale 1ns/1ps
module gpo_slave_fsm
    import gpo_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       trx_state,
    input  logic             us_tick,
    input  logic             idle_high,
    input  logic             follow_rx,
    input  logic             follow_tx,
    input  logic [DLY_W-1:0] rx_dly,
    input  logic [DLY_W-1:0] tx_dly,
    output logic             pin_o
);
    localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

    slave_state_e     st, st_nx;
    logic [DLY_W-1:0] cnt, cnt_nx;
    logic             in_rx, in_tx, rx_want, tx_want, keep, lit;

    assign in_rx   = (trx_state == TRX_RX);
    assign in_tx   = (trx_state == TRX_TX);
    assign rx_want = in_rx && follow_rx;
    assign tx_want = in_tx && follow_tx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        keep   = 1'b0;
        unique case (st)
            SL_IDLE: keep = 1'b0;
            SL_RX_WAIT: begin
                keep = rx_want;
                if (us_tick) begin
                    cnt_nx = cnt - CNT_ONE;
                    if (cnt == CNT_ONE) st_nx = SL_RX_ON;
                end
            end
            SL_RX_ON:   keep = rx_want;
            SL_TX_WAIT: begin
                keep = tx_want;
                if (us_tick) begin
                    cnt_nx = cnt - CNT_ONE;
                    if (cnt == CNT_ONE) st_nx = SL_TX_ON;
                end
            end
            SL_TX_ON:   keep = tx_want;
        endcase
        if (!keep) begin
            if (rx_want) begin
                cnt_nx = rx_dly;
                st_nx  = (rx_dly == '0) ? SL_RX_ON : SL_RX_WAIT;
            end else if (tx_want) begin
                cnt_nx = tx_dly;
                st_nx  = (tx_dly == '0) ? SL_TX_ON : SL_TX_WAIT;
            end else begin
                cnt_nx = '0;
                st_nx  = SL_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SL_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        lit   = ((st == SL_RX_ON) && rx_want) || ((st == SL_TX_ON) && tx_want);
        pin_o = (idle_high && (trx_state == TRX_ALERT || in_rx || in_tx)) ^ lit;
    end

    // R6: outside receive/transmit the tracker is idle after one edge
    a_r6_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rx && !in_tx) |=> (st == SL_IDLE));
    // R3: a waiting count is never zero
    a_r3_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SL_RX_WAIT || st == SL_TX_WAIT) |-> (cnt != '0));
    // R7: without a tick the count stays put while waiting
    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SL_RX_WAIT && rx_want && !us_tick) |=> $stable(cnt));
    // R3: a nonzero receive delay loads into the counter on entry
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SL_IDLE && rx_want && rx_dly != '0) |=>
        (st == SL_RX_WAIT && cnt == $past(rx_dly)));
endmodule

// File: rtl/gpo_pin_mux.sv
`timescale 1ns/1ps
module gpo_pin_mux (
    input  logic man_en,
    input  logic man_bit,
    input  logic lna_en,
    input  logic lna_bit,
    input  logic slave_bit,
    output logic pin_o
);
    always_comb begin
        if (man_en)      pin_o = man_bit;
        else if (lna_en) pin_o = lna_bit;
        else             pin_o = slave_bit;
    end
endmodule

// File: rtl/gpo_state_slave.sv
`timescale 1ns/1ps
module gpo_state_slave #(
    parameter int NUM_GPO = 4,
    parameter int NUM_LNA = 2,
    parameter int DLY_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               trx_state,
    input  logic                     us_tick,
    input  logic [NUM_GPO-1:0]       cfg_idle_high,
    input  logic [NUM_GPO-1:0]       cfg_follow_rx,
    input  logic [NUM_GPO-1:0]       cfg_follow_tx,
    input  logic [NUM_GPO*DLY_W-1:0] cfg_rx_dly,
    input  logic [NUM_GPO*DLY_W-1:0] cfg_tx_dly,
    input  logic                     man_en,
    input  logic [NUM_GPO-1:0]       man_mask,
    input  logic [NUM_LNA-1:0]       lna_route_en,
    input  logic [NUM_LNA-1:0]       lna_bit,
    output logic [NUM_GPO-1:0]       gpo_out
);
    logic [NUM_GPO-1:0] slave_pin, lna_sel_en, lna_sel_bit;

    for (genvar g = 0; g < NUM_GPO; g++) begin : g_pin
        gpo_slave_fsm #(.DLY_W(DLY_W)) i_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .trx_state (trx_state),
            .us_tick   (us_tick),
            .idle_high (cfg_idle_high[g]),
            .follow_rx (cfg_follow_rx[g]),
            .follow_tx (cfg_follow_tx[g]),
            .rx_dly    (cfg_rx_dly[g*DLY_W +: DLY_W]),
            .tx_dly    (cfg_tx_dly[g*DLY_W +: DLY_W]),
            .pin_o     (slave_pin[g])
        );
        if (g < NUM_LNA) begin : g_lna
            assign lna_sel_en[g]  = lna_route_en[g];
            assign lna_sel_bit[g] = lna_bit[g];
        end else begin : g_nolna
            assign lna_sel_en[g]  = 1'b0;
            assign lna_sel_bit[g] = 1'b0;
        end
        gpo_pin_mux i_mux (
            .man_en    (man_en),
            .man_bit   (man_mask[g]),
            .lna_en    (lna_sel_en[g]),
            .lna_bit   (lna_sel_bit[g]),
            .slave_bit (slave_pin[g]),
            .pin_o     (gpo_out[g])
        );
    end

    // R9: manual mask owns the pins
    a_r9_manual: assert property (@(posedge clk) disable iff (!rst_n)
        man_en |-> (gpo_out == man_mask));
    // R10: routed channel-1 LNA bit reaches pin 0
    a_r10_lna0: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_en && lna_route_en[0]) |-> (gpo_out[0] == lna_bit[0]));
    // R2: sleep and wait keep unrouted pins low
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_en && lna_route_en == '0 && trx_state <= 3'd1) |-> (gpo_out == '0));
endmodule

// File: tb/test_gpo_state_slave.sv
`timescale 1ns/1ps
module test_gpo_state_slave;
    localparam logic [2:0] S_SLEEP = 3'd0, S_WAIT = 3'd1, S_ALERT = 3'd2,
                           S_RX = 3'd3, S_TX = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  trx_state = S_SLEEP;
    logic        us_tick = 1'b0;
    logic [3:0]  cfg_idle_high = '0, cfg_follow_rx = '0, cfg_follow_tx = '0;
    logic [31:0] cfg_rx_dly = '0, cfg_tx_dly = '0;
    logic        man_en = 1'b0;
    logic [3:0]  man_mask = '0;
    logic [1:0]  lna_route_en = '0, lna_bit = '0;
    logic [3:0]  gpo_out;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    gpo_state_slave i_gpo_state_slave (
        .clk(clk), .rst_n(rst_n), .trx_state(trx_state), .us_tick(us_tick),
        .cfg_idle_high(cfg_idle_high), .cfg_follow_rx(cfg_follow_rx),
        .cfg_follow_tx(cfg_follow_tx), .cfg_rx_dly(cfg_rx_dly),
        .cfg_tx_dly(cfg_tx_dly), .man_en(man_en), .man_mask(man_mask),
        .lna_route_en(lna_route_en), .lna_bit(lna_bit), .gpo_out(gpo_out)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        #1;
        total++;
        if (gpo_out !== exp) begin
            bad++;
            $display("FAIL %s: gpo_out=%b expected=%b", req, gpo_out, exp);
        end
    endtask

    task automatic run_delay(input int g, input bit is_tx, input int d, input bit ih);
        logic [3:0] base, act;
        base = ih ? 4'hF : 4'h0;
        act = base;
        act[g] = ~ih;
        cfg_idle_high = base;
        cfg_follow_rx = is_tx ? 4'h0 : (4'h1 << g);
        cfg_follow_tx = is_tx ? (4'h1 << g) : 4'h0;
        cfg_rx_dly = {4{8'(d)}};
        cfg_tx_dly = {4{8'(d)}};
        trx_state = S_ALERT;
        step();
        trx_state = is_tx ? S_TX : S_RX;
        step();
        if (d == 0) begin
            chk(is_tx ? "R4 zero delay" : "R3 zero delay", act);
        end else begin
            for (int k = 0; k < d - 1; k++) begin
                us_tick = 1'b1;
                step();
            end
            us_tick = 1'b1;
            chk(is_tx ? "R4 before expiry" : "R3 before expiry", base);
            step();
            us_tick = 1'b0;
            chk(is_tx ? "R4 after expiry" : "R3 after expiry", act);
        end
        trx_state = S_ALERT;
        chk("R6 immediate return", base);
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #5;
        chk("R1 in reset", 4'h0);
        step();
        rst_n = 1'b1;
        step();
        chk("R1 after reset", 4'h0);

        // R2: resting levels across sleep / wait / alert
        for (int m = 0; m < 16; m++) begin
            cfg_idle_high = 4'(m);
            trx_state = S_SLEEP; chk("R2 sleep low", 4'h0);
            trx_state = S_WAIT;  chk("R2 wait low", 4'h0);
            trx_state = S_ALERT; chk("R2 alert level", 4'(m));
            step();
        end

        // R3 / R4 delay sweep per pin, direction, polarity
        for (int g = 0; g < 4; g++)
            for (int dir = 0; dir < 2; dir++)
                for (int ih = 0; ih < 2; ih++) begin
                    run_delay(g, dir[0], 0, ih[0]);
                    run_delay(g, dir[0], 1, ih[0]);
                    run_delay(g, dir[0], 3, ih[0]);
                end
        run_delay(2, 1'b0, 255, 1'b0);
        run_delay(1, 1'b1, 255, 1'b1);

        // R5: no follow enable, active states keep resting level
        cfg_idle_high = 4'b0110; cfg_follow_rx = '0; cfg_follow_tx = '0;
        cfg_rx_dly = '0; cfg_tx_dly = '0;
        trx_state = S_RX; step(); step(); chk("R5 rx not followed", 4'b0110);
        trx_state = S_TX; step(); step(); chk("R5 tx not followed", 4'b0110);

        // R7: edges without tick do not count
        cfg_idle_high = '0; cfg_follow_rx = 4'h1; cfg_rx_dly = {4{8'd2}};
        trx_state = S_ALERT; step();
        trx_state = S_RX; step();
        us_tick = 1'b1; step(); us_tick = 1'b0;
        repeat (6) step();
        chk("R7 idle edges ignored", 4'h0);
        us_tick = 1'b1; step(); us_tick = 1'b0;
        chk("R7 second tick flips", 4'h1);

        // R6: cancel of a pending delay, then full recount
        cfg_rx_dly = {4{8'd3}};
        trx_state = S_ALERT; step();
        trx_state = S_RX; step();
        us_tick = 1'b1; step(); step(); us_tick = 1'b0;
        trx_state = S_ALERT; step();
        trx_state = S_RX; step();
        us_tick = 1'b1; step(); step(); us_tick = 1'b0;
        chk("R6 delay restarted", 4'h0);
        us_tick = 1'b1; step(); us_tick = 1'b0;
        chk("R6 full delay flips", 4'h1);
        trx_state = S_SLEEP;
        chk("R6 sleep drop", 4'h0);
        step();

        // R8: direct receive to transmit
        cfg_follow_rx = 4'h1; cfg_follow_tx = 4'h1;
        cfg_rx_dly = '0; cfg_tx_dly = {4{8'd1}};
        trx_state = S_RX; step();
        chk("R8 rx on", 4'h1);
        trx_state = S_TX;
        chk("R8 drop on switch", 4'h0);
        step();
        chk("R8 tx waiting", 4'h0);
        us_tick = 1'b1; step(); us_tick = 1'b0;
        chk("R8 tx on", 4'h1);

        // R9 / R10: priority sweep (pin 0 slaved high in tx)
        for (int r = 0; r < 4; r++)
            for (int b = 0; b < 4; b++) begin
                logic [3:0] e;
                lna_route_en = 2'(r); lna_bit = 2'(b); man_en = 1'b0;
                e = 4'h1;
                if (r[0]) e[0] = b[0];
                if (r[1]) e[1] = b[1];
                chk("R10 lna routing", e);
                man_en = 1'b1;
                man_mask = 4'(r * 4 + b);
                chk("R9 manual override", 4'(r * 4 + b));
            end
        man_en = 1'b0; lna_route_en = '0;
        chk("R10 routing off", 4'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule